// File: doc/BRIEF.md
# Superpage Promotion Monitor

This block watches the stream of TLB misses on base pages and decides when an aligned group of contiguous virtual pages has cost enough in misses to justify promoting it to one large page. Every base page is 8KB and a group is sixteen neighbouring base pages on a sixteen-page boundary, so one promoted group is a 128KB region. Such a region takes a single TLB entry and must be backed by contiguous physical memory. The group number of a miss is the virtual page number with its low four bits dropped, so pages 64 to 79 form one group.

Each tracked group has a miss counter. A miss costs one unit and moving a group into contiguous memory costs `copy_cost` units. The block raises a promotion request for a group on the miss that brings its count up to that cost: a rent-or-buy rule that keeps the total spent on misses plus copying within twice what a choice made with hindsight would spend. Eight groups are tracked in a fully associative table. A miss to an untracked group takes the slot that was filled longest ago and starts it afresh. Requests leave through a valid/acknowledge handshake. Doing the copy and installing the large entry are left to the consumer of the request.

A `clear` pulse, given for instance on an address-space switch, forgets every tracked group and withdraws a request that is still waiting.

Top module: `sp_promote_mon`

## Requirements
- R1: The group of a miss is `miss_vpn[VPN_W-1:4]`; misses to any of the sixteen pages that share these bits are charged to the same counter, and `req_group` carries this group number.
- R2: Each miss sampled with `miss_valid` high adds one to its group's count; the miss that brings the count to `copy_cost` makes `req_valid` rise after the second rising clock edge from the one that sampled it, provided no request is outstanding.
- R3: A group with fewer than `copy_cost` misses charged since it was allocated raises no request.
- R4: While `req_ack` is low, `req_valid` stays high and `req_group` stays unchanged; the edge that samples `req_ack` high ends the request unless another group is waiting.
- R5: Misses that arrive while a request is outstanding are still counted; a group that reaches its cost in that time is offered on the edge that accepts the acknowledge, with no idle cycle between the two requests.
- R6: A group that has been requested is marked and raises no further request on later misses, until it is evicted or cleared.
- R7: Eight groups are tracked; a miss to a ninth group reuses the slot allocated earliest, and the evicted group starts again from a count of one on its next miss.
- R8: After reset, or on the edge following a `clear` pulse, `req_valid` is low and every count is zero, so a group requested before the clear can be requested again after `copy_cost` fresh misses.
- R9: When several groups are waiting, they are offered in the order of their slots, which after a clear is the order in which the groups were first missed.
- R10: With `copy_cost` of 0 or 1 the first miss of a group requests it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous pulse that drops all tracking and any pending request |
| miss_valid | input | 1 | A TLB miss is presented this cycle |
| miss_vpn | input | VPN_W | Virtual page number of the missing base page |
| copy_cost | input | CNT_W | Cost of promoting a group, in units of one miss; held stable between clears |
| req_valid | output | 1 | A promotion request is offered |
| req_group | output | VPN_W-4 | Group number of the offered request |
| req_ack | input | 1 | Consumer accepts the offered request on this edge |

## Verification
The bench builds the monitor with a 12-bit page number and a 4-bit counter, keeping the default eight slots. The narrow counter lets every copy cost from 0 to 15 be swept in turn, each run charging the group from scattered pages inside it and checking silence before the last miss, the request after it, the hold through a delayed acknowledge, and silence afterwards. The 256-group space is small enough to fill all eight slots and push a ninth group in, which reaches the eviction, slot-ordering and back-to-back handshake cases with short directed sequences.

// File: rtl/sp_mon_pkg.sv
package sp_mon_pkg;

   // Life of one tracking slot.
   typedef enum logic [1:0] {
      SL_FREE  = 2'd0,   // holds no group
      SL_TRACK = 2'd1,   // counting misses
      SL_READY = 2'd2,   // reached the cost, waiting to be offered
      SL_DONE  = 2'd3    // offered once, stays silent
   } slot_st_e;

   // Sixteen base pages per group.
   localparam int unsigned GRP_PAGES_LOG2 = 4;

endpackage

// File: rtl/sp_alloc_ptr.sv
module sp_alloc_ptr #(
   parameter int unsigned SLOTS = 8,
   parameter int unsigned SW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          adv,
   output logic [SW-1:0] ptr
);

   generate
      if ((SLOTS & (SLOTS - 1)) == 0) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     ptr <= '0;
            else if (clear) ptr <= '0;
            else if (adv)   ptr <= ptr + 1'b1;
         end
      end else begin : g_mod
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     ptr <= '0;
            else if (clear) ptr <= '0;
            else if (adv)   ptr <= (ptr == SW'(SLOTS - 1)) ? '0 : ptr + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/sp_group_slot.sv
module sp_group_slot
   import sp_mon_pkg::*;
#(
   parameter int unsigned GRP_W = 8,
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             miss_valid,
   input  logic [GRP_W-1:0] miss_grp,
   input  logic [CNT_W-1:0] cost,
   input  logic             alloc,
   input  logic             issue,
   output logic             hit,
   output logic             ready,
   output logic [GRP_W-1:0] tag
);

   slot_st_e         st;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_nxt;
   logic             count_en;

   assign hit      = miss_valid && (st != SL_FREE) && (tag == miss_grp);
   assign ready    = (st == SL_READY);
   assign count_en = hit && (st == SL_TRACK);
   // In TRACK the count is below the cost, so one more always fits.
   assign cnt_nxt  = cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= SL_FREE;
         cnt <= '0;
         tag <= '0;
      end else if (clear) begin
         st  <= SL_FREE;
         cnt <= '0;
      end else if (alloc) begin
         tag <= miss_grp;
         cnt <= CNT_W'(1);
         st  <= (cost <= CNT_W'(1)) ? SL_READY : SL_TRACK;
      end else if (issue) begin
         st  <= SL_DONE;
      end else if (count_en) begin
         cnt <= cnt_nxt;
         if (cnt_nxt >= cost) st <= SL_READY;
      end
   end

endmodule

// File: rtl/sp_issue_arb.sv
module sp_issue_arb #(
   parameter int unsigned SLOTS = 8,
   parameter int unsigned SW    = 3
) (
   input  logic [SLOTS-1:0] ready_vec,
   output logic             any_ready,
   output logic [SW-1:0]    sel_idx,
   output logic [SLOTS-1:0] sel_oh
);

   logic found;

   assign any_ready = |ready_vec;

   // Lowest slot first.
   always_comb begin
      found   = 1'b0;
      sel_idx = '0;
      sel_oh  = '0;
      for (int i = 0; i < int'(SLOTS); i++) begin
         if (ready_vec[i] && !found) begin
            found     = 1'b1;
            sel_idx   = SW'(i);
            sel_oh[i] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/sp_promote_mon.sv
module sp_promote_mon
   import sp_mon_pkg::*;
#(
   parameter int unsigned VPN_W = 20,
   parameter int unsigned CNT_W = 8,
   parameter int unsigned SLOTS = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              clear,
   input  logic                              miss_valid,
   input  logic [VPN_W-1:0]                  miss_vpn,
   input  logic [CNT_W-1:0]                  copy_cost,
   output logic                              req_valid,
   output logic [VPN_W-GRP_PAGES_LOG2-1:0]   req_group,
   input  logic                              req_ack
);

   localparam int unsigned GRP_W = VPN_W - GRP_PAGES_LOG2;
   localparam int unsigned SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;

   generate
      if (VPN_W <= GRP_PAGES_LOG2) begin : g_bad_vpn
         $error("VPN_W must exceed the group offset width");
      end
      if (SLOTS < 2) begin : g_bad_slots
         $error("SLOTS must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   logic [GRP_W-1:0] miss_grp;
   logic [SLOTS-1:0] hit_vec;
   logic [SLOTS-1:0] ready_vec;
   logic [SLOTS-1:0] alloc_vec;
   logic [SLOTS-1:0] issue_vec;
   logic [SLOTS-1:0] sel_oh;
   logic [GRP_W-1:0] tag_arr [SLOTS];
   logic [SW-1:0]    victim;
   logic [SW-1:0]    sel_idx;
   logic             any_hit;
   logic             any_ready;
   logic             do_alloc;
   logic             take;

   assign miss_grp = miss_vpn[VPN_W-1:GRP_PAGES_LOG2];
   assign any_hit  = |hit_vec;
   assign do_alloc = miss_valid && !any_hit && !clear;
   assign take     = any_ready && (!req_valid || req_ack) && !clear;

   sp_alloc_ptr #(.SLOTS(SLOTS), .SW(SW)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clear),
      .adv   (do_alloc),
      .ptr   (victim)
   );

   generate
      for (genvar s = 0; s < int'(SLOTS); s++) begin : g_slot
         assign alloc_vec[s] = do_alloc && (victim == SW'(s));
         assign issue_vec[s] = take && sel_oh[s];

         sp_group_slot #(.GRP_W(GRP_W), .CNT_W(CNT_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .clear      (clear),
            .miss_valid (miss_valid),
            .miss_grp   (miss_grp),
            .cost       (copy_cost),
            .alloc      (alloc_vec[s]),
            .issue      (issue_vec[s]),
            .hit        (hit_vec[s]),
            .ready      (ready_vec[s]),
            .tag        (tag_arr[s])
         );
      end
   endgenerate

   sp_issue_arb #(.SLOTS(SLOTS), .SW(SW)) u_arb (
      .ready_vec (ready_vec),
      .any_ready (any_ready),
      .sel_idx   (sel_idx),
      .sel_oh    (sel_oh)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_valid <= 1'b0;
         req_group <= '0;
      end else if (clear) begin
         req_valid <= 1'b0;
      end else if (take) begin
         req_valid <= 1'b1;
         req_group <= tag_arr[sel_idx];
      end else if (req_ack) begin
         req_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/sp_promote_mon_chk.sv
module sp_promote_mon_chk #(
   parameter int unsigned GRP_W = 16,
   parameter int unsigned SLOTS = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clear,
   input logic             req_valid,
   input logic             req_ack,
   input logic [GRP_W-1:0] req_group,
   input logic [SLOTS-1:0] hit_vec,
   input logic             any_ready
);

   // R1: a group lives in at most one slot
   a_r1_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R2: a request only appears when some group had reached its cost
   a_r2_rise_from_ready: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_valid) |-> $past(any_ready));

   // R4: the request holds until accepted
   a_r4_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ack && !clear) |=> req_valid);

   // R4: the group number holds until accepted
   a_r4_hold_group: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ack && !clear) |=> $stable(req_group));

   // R8: clear withdraws any request
   a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !req_valid);

endmodule

bind sp_promote_mon sp_promote_mon_chk #(.GRP_W(GRP_W), .SLOTS(SLOTS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clear     (clear),
   .req_valid (req_valid),
   .req_ack   (req_ack),
   .req_group (req_group),
   .hit_vec   (hit_vec),
   .any_ready (any_ready)
);

// File: tb/sim_sp_promote_mon.sv
module sim_sp_promote_mon;

   localparam int CLK_P = 10;
   localparam int VPN_W = 12;
   localparam int CNT_W = 4;
   localparam int SLOTS = 8;
   localparam int GRP_W = VPN_W - 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             clear = 1'b0;
   logic             miss_valid = 1'b0;
   logic [VPN_W-1:0] miss_vpn = '0;
   logic [CNT_W-1:0] copy_cost = '0;
   logic             req_valid;
   logic [GRP_W-1:0] req_group;
   logic             req_ack = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   sp_promote_mon #(.VPN_W(VPN_W), .CNT_W(CNT_W), .SLOTS(SLOTS)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (clear),
      .miss_valid (miss_valid),
      .miss_vpn   (miss_vpn),
      .copy_cost  (copy_cost),
      .req_valid  (req_valid),
      .req_group  (req_group),
      .req_ack    (req_ack)
   );

   task automatic check(input string req, input int got, input int exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   // All tasks start and end at a falling edge.
   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_clear();
      clear = 1'b1;
      @(negedge clk);
      clear = 1'b0;
   endtask

   task automatic miss(input int grp, input int page);
      miss_valid = 1'b1;
      miss_vpn   = VPN_W'(grp * 16 + (page % 16));
      @(negedge clk);
      miss_valid = 1'b0;
   endtask

   task automatic ack();
      req_ack = 1'b1;
      @(negedge clk);
      req_ack = 1'b0;
   endtask

   // n misses to a group, scattered over its pages
   task automatic misses(input int grp, input int n);
      for (int k = 0; k < n; k++) miss(grp, k * 7 + 3);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: got %0d expected %0d", 0, 1);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      idle(3);
      check("R8 reset req_valid", int'(req_valid), 0);
      rst_n = 1'b1;
      idle(2);
      check("R8 idle after reset", int'(req_valid), 0);

      // Sweep of every copy cost (R1, R2, R3, R4, R6, R10)
      for (int c = 0; c < 16; c++) begin
         int g;
         int need;
         g    = (c * 37 + 5) % 256;
         need = (c == 0) ? 1 : c;
         copy_cost = CNT_W'(c);
         do_clear();
         misses(g, need - 1);
         idle(2);
         check("R3 below cost silent", int'(req_valid), 0);
         miss(g, 15);          // now one edge past the sampling edge
         check("R2 not before second edge", int'(req_valid), 0);
         idle(1);
         check(c <= 1 ? "R10 first miss requests" : "R2 request at cost",
               int'(req_valid), 1);
         check("R1 group number", int'(req_group), g);
         idle(3);
         check("R4 hold valid", int'(req_valid), 1);
         check("R4 hold group", int'(req_group), g);
         ack();
         check("R4 drop after ack", int'(req_valid), 0);
         misses(g, c + 2);
         idle(2);
         check("R6 promoted group silent", int'(req_valid), 0);
      end

      // R5: counting during a pending request, back-to-back offer
      copy_cost = 4'd3;
      do_clear();
      misses(10, 3);
      idle(1);
      check("R5 first request", int'(req_group), 10);
      misses(20, 3);
      idle(3);
      check("R5 first held", int'(req_group), 10);
      ack();
      check("R5 second valid at ack", int'(req_valid), 1);
      check("R5 second group", int'(req_group), 20);
      ack();
      check("R5 drop", int'(req_valid), 0);

      // R9: slot order after a clear
      copy_cost = 4'd2;
      do_clear();
      misses(1, 2);
      idle(1);
      check("R9 first", int'(req_group), 1);
      miss(30, 0);
      miss(31, 0);
      miss(32, 0);
      miss(32, 1);
      miss(31, 1);
      miss(30, 1);
      idle(2);
      ack();
      check("R9 order 1", int'(req_group), 30);
      ack();
      check("R9 order 2", int'(req_group), 31);
      ack();
      check("R9 order 3", int'(req_group), 32);
      ack();
      check("R9 drained", int'(req_valid), 0);

      // R7: eviction of the earliest slot
      copy_cost = 4'd4;
      do_clear();
      for (int k = 0; k < 8; k++) miss(100 + k, k);
      misses(100, 2);           // group 100 at 3
      miss(200, 0);             // ninth group evicts 100
      miss(100, 9);             // would be 4th, restarts at 1
      idle(2);
      check("R7 evicted restarts", int'(req_valid), 0);
      misses(100, 3);
      idle(1);
      check("R7 re-tracked request", int'(req_valid), 1);
      check("R7 re-tracked group", int'(req_group), 100);
      ack();

      // R8: clear drops request and promoted marks
      copy_cost = 4'd2;
      do_clear();
      misses(55, 2);
      idle(1);
      check("R8 pending before clear", int'(req_valid), 1);
      do_clear();
      check("R8 clear drops request", int'(req_valid), 0);
      miss(55, 4);
      idle(2);
      check("R8 count restarted", int'(req_valid), 0);
      miss(55, 5);
      idle(1);
      check("R8 promotable again", int'(req_valid), 1);
      check("R8 group again", int'(req_group), 55);
      ack();

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule